// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block is the host-side master for a three-wire successive-approximation converter. It drives an active-low chip select and a serial clock divided down from the system clock. It shifts in the converter's data line on each rising serial clock edge and turns every complete 16-clock frame into a 12-bit unsigned sample, which it presents with a one-cycle strobe.

Frames start from a single-cycle request or run back to back in a free-running mode. Between frames the block holds chip select high for at least a programmable quiet count. It also holds off the next chip-select fall until a programmable acquisition count has passed since the 13th rising serial edge. A low-power mode ends each frame early, at a chosen falling edge, and no sample is produced. The first complete frame after reset, or after an early-ended frame, is treated as a warm-up conversion and thrown away.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted, csN and sclk are high and sampleValid and busy are low.
- R2: Chip select falls only while sclk is high, and sclk idles high whenever chip select is high. A full frame has exactly 16 falling sclk edges while csN is low. Consecutive falling edges are 2*halfDiv system cycles apart.
- R3: Rising sclk edges are numbered 1 to 16 from the chip-select fall. The bits sampled on edges 4 to 15 form the sample, first bit as bit 11. The bits on edges 1 to 3 and edge 16 have no effect on the sample.
- R4: The first complete frame after reset produces no sampleValid. Every later complete frame produces one.
- R5: sampleValid is a single-cycle pulse in the cycle after chip select rises at the end of a kept frame. The sample output holds its value until the next pulse.
- R6: At least acqCount system cycles separate the 13th rising sclk edge of a frame from the next chip-select fall. For an early-ended frame, the count runs from its chip-select rise.
- R7: Chip select stays high for at least quietCount system cycles between frames.
- R8: With lowPower set, chip select rises after falling edge number cutEdge, before any further falling edge. Such a frame therefore has cutEdge falling edges (valid cutEdge values are 11 to 14), and it produces no sampleValid.
- R9: After an early-ended frame, the next complete frame is discarded as a warm-up frame. The frame after that produces a sample.
- R10: A startReq that arrives while busy is high has no effect. It starts no additional frame.
- R11: With freeRun set, frames follow each other without requests. Each new frame begins within two cycles after both the quiet and the acquisition counts are met.
- R12: busy rises in the cycle after an accepted startReq and stays high until chip select rises at the end of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Single-cycle request for one frame |
| freeRun | input | 1 | Start frames continuously |
| lowPower | input | 1 | End each frame early at cutEdge |
| halfDiv | input | DIV_W | System cycles per half serial clock period (0 acts as 1) |
| acqCount | input | CNT_W | Minimum cycles from rising edge 13 to the next chip-select fall |
| quietCount | input | CNT_W | Minimum cycles chip select stays high |
| cutEdge | input | EDGE_W | Falling edge after which a low-power frame ends |
| sdIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | A request is pending or a frame is running |
| sample | output | DATA_W | Last kept conversion result |
| sampleValid | output | 1 | One-cycle strobe for a new sample |

## Verification
The end of a full frame coincides with two events in the same cycle. Chip select rises, and the warm-up flag decides whether the assembled word becomes a sample. This is provoked by the first frame after reset, by the frame that follows an early-ended low-power frame, and by the frame after that one. Each case is judged by counting sampleValid pulses at the ports against the expected dummy or keep outcome. The converter model also drives ones into the discarded lead and trail bit slots, so any misalignment of the capture window shows up in the sample values.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH
  } frameState_t;

  typedef struct packed {
    logic clearShift;
    logic capture;
    logic load;
    logic keep;
  } dpStrobes_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 10,
  parameter int EDGE_W     = 5,
  parameter int FRAME_BITS = 16,
  parameter int ACQ_EDGE   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              freeRun,
  input  logic              lowPower,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [CNT_W-1:0]  acqCount,
  input  logic [CNT_W-1:0]  quietCount,
  input  logic [EDGE_W-1:0] cutEdge,
  output logic              csN,
  output logic              sclk,
  output logic              busy,
  output dpStrobes_t        strobes
);

  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_BITS);
  localparam logic [EDGE_W-1:0] ACQ_MARK  = EDGE_W'(ACQ_EDGE);
  localparam logic [CNT_W-1:0]  CNT_SAT   = '1;

  frameState_t       state;
  logic [DIV_W-1:0]  ph;
  logic [EDGE_W-1:0] edgeN;
  logic              pending;
  logic              needDummy;
  logic [CNT_W-1:0]  acqCnt;
  logic [CNT_W-1:0]  quietCnt;

  logic phEnd, gapsOk, go, cutNow;

  assign phEnd  = (DIV_W'(ph + 1'b1) >= halfDiv);
  assign gapsOk = (acqCnt >= acqCount) && (quietCnt >= quietCount);
  assign go     = (state == ST_IDLE) && (pending || freeRun) && gapsOk;
  assign cutNow = lowPower && (edgeN == cutEdge);
  assign busy   = pending || (state != ST_IDLE);

  always_comb begin
    strobes.clearShift = go;
    strobes.capture    = (state == ST_LOW) && phEnd && !cutNow;
    strobes.load       = (state == ST_HIGH) && phEnd && (edgeN == LAST_EDGE);
    strobes.keep       = !needDummy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ph        <= '0;
      edgeN     <= '0;
      csN       <= 1'b1;
      sclk      <= 1'b1;
      pending   <= 1'b0;
      needDummy <= 1'b1;
      acqCnt    <= CNT_SAT;
      quietCnt  <= CNT_SAT;
    end else begin
      if (acqCnt != CNT_SAT)   acqCnt   <= acqCnt + 1'b1;
      if (quietCnt != CNT_SAT) quietCnt <= quietCnt + 1'b1;
      if (startReq && !busy)   pending  <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            csN     <= 1'b0;
            state   <= ST_SETUP;
            ph      <= '0;
            edgeN   <= '0;
            pending <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (phEnd) begin
            ph    <= '0;
            sclk  <= 1'b0;
            edgeN <= EDGE_W'(1);
            state <= ST_LOW;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_LOW: begin
          if (phEnd) begin
            ph <= '0;
            if (cutNow) begin
              csN       <= 1'b1;
              sclk      <= 1'b1;
              state     <= ST_IDLE;
              needDummy <= 1'b1;
              acqCnt    <= '0;
              quietCnt  <= '0;
            end else begin
              sclk  <= 1'b1;
              state <= ST_HIGH;
              if (edgeN == ACQ_MARK) acqCnt <= '0;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phEnd) begin
            ph <= '0;
            if (edgeN == LAST_EDGE) begin
              csN       <= 1'b1;
              state     <= ST_IDLE;
              needDummy <= 1'b0;
              quietCnt  <= '0;
            end else begin
              sclk  <= 1'b0;
              edgeN <= edgeN + 1'b1;
              state <= ST_LOW;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  csFallSclkHigh_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> sclk);

  // R2
  sclkIdleHigh_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R7
  quietMet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (quietCnt >= quietCount));

  // R6
  acqMet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (acqCnt >= acqCount));

  // R12
  busyCovers_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int LEAD_ZEROS = 3,
  parameter int DATA_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              sdIn,
  output logic [DATA_W-1:0] sample,
  output logic              sampleValid
);

  localparam int MSB_POS = FRAME_BITS - 1 - LEAD_ZEROS;

  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg       <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (strobes.clearShift)   shreg <= '0;
      else if (strobes.capture) shreg <= {shreg[FRAME_BITS-2:0], sdIn};
      sampleValid <= strobes.load && strobes.keep;
      if (strobes.load && strobes.keep) sample <= shreg[MSB_POS -: DATA_W];
    end
  end

  // R5
  validPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R5
  sampleHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sample));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_frame_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 10,
  parameter int EDGE_W     = 5,
  parameter int FRAME_BITS = 16,
  parameter int LEAD_ZEROS = 3,
  parameter int DATA_W     = 12,
  parameter int ACQ_EDGE   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              freeRun,
  input  logic              lowPower,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [CNT_W-1:0]  acqCount,
  input  logic [CNT_W-1:0]  quietCount,
  input  logic [EDGE_W-1:0] cutEdge,
  input  logic              sdIn,
  output logic              csN,
  output logic              sclk,
  output logic              busy,
  output logic [DATA_W-1:0] sample,
  output logic              sampleValid
);

  dpStrobes_t strobes;

  adc_frame_ctrl #(
    .DIV_W(DIV_W), .CNT_W(CNT_W), .EDGE_W(EDGE_W),
    .FRAME_BITS(FRAME_BITS), .ACQ_EDGE(ACQ_EDGE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .lowPower(lowPower), .halfDiv(halfDiv), .acqCount(acqCount),
    .quietCount(quietCount), .cutEdge(cutEdge), .csN(csN), .sclk(sclk),
    .busy(busy), .strobes(strobes)
  );

  adc_frame_dp #(
    .FRAME_BITS(FRAME_BITS), .LEAD_ZEROS(LEAD_ZEROS), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdIn(sdIn),
    .sample(sample), .sampleValid(sampleValid)
  );

endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;

  localparam int DIV_W = 8;
  localparam int CNT_W = 10;
  localparam int EDGE_W = 5;
  localparam int NVEC = 6;
  localparam logic [11:0] VECS [NVEC] = '{12'h000, 12'hFFF, 12'h800, 12'h001, 12'hA5C, 12'h3C7};

  logic clk = 1'b0;
  logic rstN, startReq, freeRun, lowPower, sdIn;
  logic [DIV_W-1:0] halfDiv;
  logic [CNT_W-1:0] acqCount, quietCount;
  logic [EDGE_W-1:0] cutEdge;
  logic csN, sclk, busy, sampleValid;
  logic [11:0] sample;

  int checks = 0, failures = 0;
  int fallCnt = 0, riseCnt = 0, lastFalls = 0, frameCnt = 0, validCnt = 0;
  int expFalls = 16, lastHigh = 0;
  logic [11:0] convVal = '0, lastSample = '0;
  logic prevValid = 1'b0, haveRise = 1'b0;
  time tRise = 0, t13 = 0, tFall = 0;

  always #4 clk = ~clk;

  adc_frame_reader dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .lowPower(lowPower), .halfDiv(halfDiv), .acqCount(acqCount),
    .quietCount(quietCount), .cutEdge(cutEdge), .sdIn(sdIn), .csN(csN),
    .sclk(sclk), .busy(busy), .sample(sample), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: slot k shown after falling edge k; slots 4..15 carry data, others junk ones
  always_comb begin
    if (fallCnt >= 4 && fallCnt <= 15) sdIn = convVal[15 - fallCnt];
    else sdIn = 1'b1;
  end

  always @(negedge csN) begin
    check(sclk === 1'b1, "R2 cs fall with sclk high", int'(sclk), 1);
    if (haveRise) begin
      lastHigh = int'(($time - tRise) / 8);
      check(lastHigh >= int'(quietCount), "R7 quiet gap", lastHigh, int'(quietCount));
      check(int'(($time - t13) / 8) >= int'(acqCount), "R6 acquisition gap",
            int'(($time - t13) / 8), int'(acqCount));
    end
    fallCnt = 0;
    riseCnt = 0;
    frameCnt++;
  end

  always @(posedge csN) begin
    if (rstN) begin
      lastFalls = fallCnt;
      check(fallCnt == expFalls, "R2 R8 falling edges per frame", fallCnt, expFalls);
      if (riseCnt < 13) t13 = $time;
      tRise = $time;
      haveRise = 1'b1;
    end
  end

  always @(negedge sclk) begin
    if (!csN) begin
      if (fallCnt >= 1)
        check(($time - tFall) == time'(16 * int'(halfDiv)), "R2 sclk period",
              int'(($time - tFall) / 8), 2 * int'(halfDiv));
      tFall = $time;
      fallCnt++;
    end
  end

  always @(posedge sclk) begin
    if (!csN) begin
      riseCnt++;
      if (riseCnt == 13) t13 = $time;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        validCnt++;
        lastSample = sample;
        check(!prevValid, "R5 valid single pulse", 1, 0);
        check(csN === 1'b1, "R5 valid after cs rise", int'(csN), 1);
      end
      prevValid = sampleValid;
    end
  end

  task automatic runFrame();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    @(negedge csN);
    @(posedge csN);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v0, f0;
    rstN = 1'b0; startReq = 1'b0; freeRun = 1'b0; lowPower = 1'b0;
    halfDiv = 8'd2; acqCount = 10'd20; quietCount = 10'd6; cutEdge = 5'd12;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(csN === 1'b1 && sclk === 1'b1, "R1 cs and sclk high", int'({csN, sclk}), 3);
    check(sampleValid === 1'b0 && busy === 1'b0, "R1 valid and busy low", int'({sampleValid, busy}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R4 first frame after reset is a warm-up
    convVal = 12'h5A5;
    runFrame();
    check(validCnt == 0, "R4 warm-up frame discarded", validCnt, 0);

    // R3 R4 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      convVal = VECS[i];
      v0 = validCnt;
      runFrame();
      check(validCnt == v0 + 1, "R4 one sample per frame", validCnt, v0 + 1);
      check(lastSample == VECS[i], "R3 sample value", int'(lastSample), int'(VECS[i]));
      check(sample == VECS[i], "R5 sample held", int'(sample), int'(VECS[i]));
    end

    // R12 busy and R10 ignored request
    f0 = frameCnt;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(busy === 1'b1, "R12 busy after request", int'(busy), 1);
    @(negedge csN);
    repeat (5) @(negedge clk);
    check(busy === 1'b1, "R12 busy during frame", int'(busy), 1);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    @(posedge csN);
    repeat (80) @(negedge clk);
    check(frameCnt == f0 + 1, "R10 request while busy ignored", frameCnt - f0, 1);
    check(busy === 1'b0, "R12 busy clears", int'(busy), 0);

    // R8 low-power early end
    lowPower = 1'b1; expFalls = 12;
    v0 = validCnt;
    runFrame();
    check(lastFalls == 12, "R8 cs rises after cut edge", lastFalls, 12);
    check(validCnt == v0, "R8 no sample on early end", validCnt, v0);
    lowPower = 1'b0; expFalls = 16;
    // R9 warm-up after early end
    convVal = 12'h6B2;
    runFrame();
    check(validCnt == v0, "R9 warm-up after early end", validCnt, v0);
    runFrame();
    check(validCnt == v0 + 1, "R9 sample after warm-up", validCnt, v0 + 1);
    check(lastSample == 12'h6B2, "R9 sample value", int'(lastSample), 32'h6B2);

    // R11 free-running with other divider and gaps
    halfDiv = 8'd3; acqCount = 10'd40; quietCount = 10'd30; convVal = 12'h9E1;
    repeat (2) @(negedge clk);
    v0 = validCnt;
    freeRun = 1'b1;
    for (int n = 0; n < 5000 && validCnt < v0 + 3; n++) @(negedge clk);
    check(validCnt == v0 + 3, "R11 free-run frames", validCnt - v0, 3);
    check(lastHigh <= int'(quietCount) + 2, "R11 back-to-back spacing", lastHigh, int'(quietCount) + 1);
    check(lastSample == 12'h9E1, "R11 free-run sample", int'(lastSample), 32'h9E1);
    freeRun = 1'b0;
    for (int n = 0; n < 400 && (busy || !csN); n++) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule